// File: doc/BRIEF.md
# Timer Channel Control and Interrupt Register Bank

This block is the shared register front end for a group of eight timer channels. It decodes a word-aligned 32-bit read/write bus. For each channel it decodes a 16-byte window and passes the window's accesses to the counter logic as select strobes with a word index. The counters are outside this block. The block itself keeps three pieces of shared state: a control word with four bits per channel, a sticky interrupt-status register fed by one event pulse per channel, and a lock that guards a clear-by-ones view of the control word.

Control changes are applied in a fixed order. When a write stops a channel, the enable drops in the same cycle as the new configuration bits. When a write starts a channel, the configuration settles one cycle before the enable rises. This lets a counter latch its clock source and interrupt mode before it starts running. A one-cycle strobe marks each start and each stop. Interrupt status is cleared by writing an AND mask. An event that arrives in the same cycle as that write wins, so the event is never lost.

Top module: `tcb_bank`

## Requirements
- R1: Channel id i (0..7) owns the 16-byte window whose address bits [7:4] equal i for i below 3 and i+1 otherwise (0x00, 0x10, 0x20, then 0x40..0x80). An aligned access to that window raises bit i of `slot_wr` or `slot_rd` in the same cycle, with `slot_word` = address bits [3:2] (0 count, 1 reload, 2 first match, 3 second match). A read returns `tmr_rdata` on `rd_data` in the next cycle.
- R2: Offset 0x30 holds the control word. Channel i uses bits [4i+3:4i]: bit 4i enable, 4i+1 external clock, 4i+2 overflow interrupt, 4i+3 pulse mode. A read returns the last value applied.
- R3: After a control change is accepted at a clock edge, the configuration outputs (`ctl_ext_clk`, `ctl_ovf_irq`, `ctl_pulse`) change in the next cycle. A stop lowers `ctl_en` in that same cycle and raises `en_fall` for one cycle. A start raises `ctl_en` and `en_rise` for one cycle, one cycle later than the configuration. If a stop is written while a start is still pending, the channel never rises and no strobe is issued.
- R4: The pulse-mode bit drives `ctl_pulse` only for channels 4..7. Setting it from 0 to 1 on channels 0..3 raises `pulse_err` for one cycle. The bit still reads back.
- R5: A write to 0x3C clears each control bit written as 1, with the same ordering as R3, but only while the clear path is unlocked.
- R6: A write to 0x38 unlocks the clear path when data bits [8:1] equal 0xAE and locks it when they equal 0xEA. Any other value leaves the lock unchanged. A read of 0x38 returns the lock state in bit 0 (1 = unlocked).
- R7: Offset 0x34 is the interrupt status. An event pulse on channel i sets bit i. A write ANDs the register with the written data.
- R8: An event that arrives in the same cycle as a status write leaves its bit set.
- R9: A misaligned address (bits [1:0] not zero) or an unmapped offset reads as zero, changes no state and raises no select strobe. Offset 0x3C reads as zero.
- R10: Synchronous active-low reset clears the control word, the lock (locked), the status register, every strobe and `rd_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_wr | input | 1 | Write request, one cycle per access |
| bus_rd | input | 1 | Read request, one cycle per access |
| bus_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid the cycle after `bus_rd` |
| tmr_rdata | input | 32 | Data from the selected channel, combinational on `slot_rd` |
| evt_pulse | input | 8 | One event pulse per channel |
| slot_wr | output | 8 | One-hot channel window write strobe |
| slot_rd | output | 8 | One-hot channel window read strobe |
| slot_word | output | 2 | Word index inside the window |
| ctl_en | output | 8 | Channel enable |
| ctl_ext_clk | output | 8 | External clock select |
| ctl_ovf_irq | output | 8 | Overflow interrupt enable |
| ctl_pulse | output | 8 | Pulse mode (channels 4..7 only) |
| en_rise | output | 8 | One-cycle strobe when a channel starts |
| en_fall | output | 8 | One-cycle strobe when a channel stops |
| pulse_err | output | 1 | One-cycle flag for pulse mode set on an incapable channel |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a channel event and a status write. The bench drives an event pulse together with a write of all zeros to 0x34, then reads the register back. The expected result is that the other bits clear and the event's bit stays set. The second pair is a pending start and a stop, provoked by two back-to-back control writes that enable and then disable a channel; the expected result is that `ctl_en`, `en_rise` and `en_fall` all stay low in every cycle that follows.

// File: rtl/tcb_pkg.sv
// Shared constants and types for the timer control register bank.
// Assumes byte addressing with 32-bit words and at most eight channels.
package tcb_pkg;
    // Shared register offsets (low address byte)
    localparam logic [7:0] OFS_CTL  = 8'h30;
    localparam logic [7:0] OFS_STS  = 8'h34;
    localparam logic [7:0] OFS_LOCK = 8'h38;
    localparam logic [7:0] OFS_CLR  = 8'h3C;

    // Lock key values carried in write data bits [8:1]
    localparam logic [7:0] KEY_OPEN  = 8'hAE;
    localparam logic [7:0] KEY_CLOSE = 8'hEA;

    // Bit positions inside a channel's control nibble
    localparam int NB_EN    = 0;
    localparam int NB_EXT   = 1;
    localparam int NB_OVF   = 2;
    localparam int NB_PULSE = 3;

    // Which shared register an access hits
    typedef struct packed {
        logic ctl;
        logic sts;
        logic lock;
        logic clr;
    } hit_t;

    // Address bits [7:4] of a channel's window: the control block occupies 3
    function automatic logic [3:0] slot_nibble(input int id);
        return (id < 3) ? 4'(id) : 4'(id + 1);
    endfunction
endpackage

// File: rtl/tcb_decode.sv
// Address decoder: maps a bus address to a shared register hit or a one-hot
// channel window. Assumes ADDR_W > 8; misaligned addresses hit nothing.
module tcb_decode
    import tcb_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int NUM_TIMERS = 8
) (
    input  logic [ADDR_W-1:0]     addr,
    output hit_t                  hit,
    output logic [NUM_TIMERS-1:0] slot_oh
);
    logic base_ok;

    // Word aligned and inside the first 256 bytes
    assign base_ok = (addr[1:0] == 2'b00) && (addr[ADDR_W-1:8] == '0);

    // Shared register hits
    always_comb begin
        hit.ctl  = base_ok && (addr[7:0] == OFS_CTL);
        hit.sts  = base_ok && (addr[7:0] == OFS_STS);
        hit.lock = base_ok && (addr[7:0] == OFS_LOCK);
        hit.clr  = base_ok && (addr[7:0] == OFS_CLR);
    end

    // One window decoder per channel
    for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_slot
        assign slot_oh[i] = base_ok && (addr[7:4] == slot_nibble(i));
    end
endmodule

// File: rtl/tcb_ctrl_seq.sv
// Control word holder with ordered application: a stop takes effect together
// with the new configuration; a start takes effect one cycle after it.
// Assumes at most one apply per cycle; readback shows pending starts as set.
module tcb_ctrl_seq
    import tcb_pkg::*;
#(
    parameter int NUM_TIMERS = 8,
    parameter int PULSE_MIN  = 4,
    localparam int CW        = 4 * NUM_TIMERS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  apply,
    input  logic [CW-1:0]         new_word,
    output logic [CW-1:0]         cur_word,
    output logic [NUM_TIMERS-1:0] ctl_en,
    output logic [NUM_TIMERS-1:0] ctl_ext_clk,
    output logic [NUM_TIMERS-1:0] ctl_ovf_irq,
    output logic [NUM_TIMERS-1:0] ctl_pulse,
    output logic [NUM_TIMERS-1:0] en_rise,
    output logic [NUM_TIMERS-1:0] en_fall,
    output logic                  pulse_err
);
    logic [NUM_TIMERS-1:0] perr_v;

    for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_ch
        localparam int B = 4 * i;
        logic       en_q, pend_q, rise_q, fall_q;
        logic [2:0] cfg_q;   // {pulse, ovf, ext}
        logic       old_on, new_on;

        assign old_on = en_q | pend_q;
        assign new_on = new_word[B + NB_EN];

        // Stage the enable: stop now, start one cycle after configuration
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q   <= 1'b0;
                pend_q <= 1'b0;
                rise_q <= 1'b0;
                fall_q <= 1'b0;
                cfg_q  <= 3'b000;
            end else begin
                rise_q <= 1'b0;
                fall_q <= 1'b0;
                if (apply) begin
                    cfg_q <= new_word[B + NB_EXT +: 3];
                end
                if (apply && old_on && !new_on) begin
                    en_q   <= 1'b0;
                    pend_q <= 1'b0;
                    fall_q <= en_q;
                end else if (apply && !old_on && new_on) begin
                    pend_q <= 1'b1;
                end else if (pend_q) begin
                    en_q   <= 1'b1;
                    pend_q <= 1'b0;
                    rise_q <= 1'b1;
                end
            end
        end

        assign cur_word[B +: 4] = {cfg_q, old_on};
        assign ctl_en[i]        = en_q;
        assign ctl_ext_clk[i]   = cfg_q[0];
        assign ctl_ovf_irq[i]   = cfg_q[1];
        assign en_rise[i]       = rise_q;
        assign en_fall[i]       = fall_q;

        if (i >= PULSE_MIN) begin : g_pulse
            assign ctl_pulse[i] = cfg_q[2];
            assign perr_v[i]    = 1'b0;
        end else begin : g_nopulse
            assign ctl_pulse[i] = 1'b0;
            assign perr_v[i]    = apply && new_word[B + NB_PULSE] && !cfg_q[2];
        end
    end

    // Register the misuse flag as a one-cycle strobe
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_err <= 1'b0;
        else        pulse_err <= |perr_v;
    end
endmodule

// File: rtl/tcb_irq_status.sv
// Sticky per-channel event status, cleared by an AND-mask write.
// An event in the same cycle as a write keeps its bit set.
module tcb_irq_status #(
    parameter int NUM_TIMERS = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr,
    input  logic [NUM_TIMERS-1:0] mask,
    input  logic [NUM_TIMERS-1:0] evt,
    output logic [NUM_TIMERS-1:0] sts
);
    // Mask on write, then merge new events
    always_ff @(posedge clk) begin
        if (!rst_n) sts <= '0;
        else        sts <= (wr ? (sts & mask) : sts) | evt;
    end
endmodule

// File: rtl/tcb_lock.sv
// Key-operated lock for the clear path. With HAS_LOCK = 0 the clear path is
// always open and the lock reads as zero.
module tcb_lock
    import tcb_pkg::*;
#(
    parameter bit HAS_LOCK = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [7:0] key,
    output logic       clr_ok,
    output logic       lock_bit
);
    if (HAS_LOCK) begin : g_lock
        logic open_q;
        // Open or close on a matching key, hold otherwise
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_q <= 1'b0;
            end else if (wr) begin
                if (key == KEY_OPEN)       open_q <= 1'b1;
                else if (key == KEY_CLOSE) open_q <= 1'b0;
            end
        end
        assign clr_ok   = open_q;
        assign lock_bit = open_q;
    end else begin : g_nolock
        assign clr_ok   = 1'b1;
        assign lock_bit = 1'b0;
    end
endmodule

// File: rtl/tcb_bank.sv
// Top of the timer control register bank: decodes the bus, routes writes to
// the control, status and lock holders, strobes channel windows and returns
// registered read data. Assumes bus_rd and bus_wr are single-cycle requests
// and tmr_rdata answers combinationally to slot_rd.
module tcb_bank
    import tcb_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int NUM_TIMERS = 8,
    parameter int PULSE_MIN  = 4,
    parameter bit HAS_LOCK   = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           rd_data,
    input  logic [31:0]           tmr_rdata,
    input  logic [NUM_TIMERS-1:0] evt_pulse,
    output logic [NUM_TIMERS-1:0] slot_wr,
    output logic [NUM_TIMERS-1:0] slot_rd,
    output logic [1:0]            slot_word,
    output logic [NUM_TIMERS-1:0] ctl_en,
    output logic [NUM_TIMERS-1:0] ctl_ext_clk,
    output logic [NUM_TIMERS-1:0] ctl_ovf_irq,
    output logic [NUM_TIMERS-1:0] ctl_pulse,
    output logic [NUM_TIMERS-1:0] en_rise,
    output logic [NUM_TIMERS-1:0] en_fall,
    output logic                  pulse_err
);
    localparam int CW = 4 * NUM_TIMERS;

    hit_t                  hit;
    logic [NUM_TIMERS-1:0] slot_oh;
    logic [CW-1:0]         cur_word;
    logic [CW-1:0]         new_word;
    logic [NUM_TIMERS-1:0] sts_q;
    logic                  clr_ok, lock_bit, ctl_apply;
    logic [31:0]           rd_next;

    tcb_decode #(.ADDR_W(ADDR_W), .NUM_TIMERS(NUM_TIMERS)) u_dec (
        .addr    (bus_addr),
        .hit     (hit),
        .slot_oh (slot_oh)
    );

    // Channel window strobes follow the bus in the same cycle
    assign slot_wr   = {NUM_TIMERS{bus_wr}} & slot_oh;
    assign slot_rd   = {NUM_TIMERS{bus_rd}} & slot_oh;
    assign slot_word = bus_addr[3:2];

    tcb_lock #(.HAS_LOCK(HAS_LOCK)) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (bus_wr && hit.lock),
        .key      (bus_wdata[8:1]),
        .clr_ok   (clr_ok),
        .lock_bit (lock_bit)
    );

    // Direct control write or permitted clear-by-ones write
    assign ctl_apply = bus_wr && (hit.ctl || (hit.clr && clr_ok));
    assign new_word  = hit.clr ? (cur_word & ~bus_wdata[CW-1:0]) : bus_wdata[CW-1:0];

    tcb_ctrl_seq #(.NUM_TIMERS(NUM_TIMERS), .PULSE_MIN(PULSE_MIN)) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .apply       (ctl_apply),
        .new_word    (new_word),
        .cur_word    (cur_word),
        .ctl_en      (ctl_en),
        .ctl_ext_clk (ctl_ext_clk),
        .ctl_ovf_irq (ctl_ovf_irq),
        .ctl_pulse   (ctl_pulse),
        .en_rise     (en_rise),
        .en_fall     (en_fall),
        .pulse_err   (pulse_err)
    );

    tcb_irq_status #(.NUM_TIMERS(NUM_TIMERS)) u_sts (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (bus_wr && hit.sts),
        .mask  (bus_wdata[NUM_TIMERS-1:0]),
        .evt   (evt_pulse),
        .sts   (sts_q)
    );

    // Select read source; clear register and unmapped offsets give zero
    always_comb begin
        rd_next = '0;
        if (hit.ctl)       rd_next = 32'(cur_word);
        else if (hit.sts)  rd_next = 32'(sts_q);
        else if (hit.lock) rd_next = {31'b0, lock_bit};
        else if (|slot_oh) rd_next = tmr_rdata;
    end

    // Register read data for one cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_data <= '0;
        else if (bus_rd) rd_data <= rd_next;
        else             rd_data <= '0;
    end
endmodule

// File: rtl/tcb_bank_chk.sv
// Property checker for tcb_bank, attached with bind below.
module tcb_bank_chk #(
    parameter int ADDR_W     = 12,
    parameter int NUM_TIMERS = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    bus_wr,
    input logic [ADDR_W-1:0]       bus_addr,
    input logic [NUM_TIMERS-1:0]   evt_pulse,
    input logic [NUM_TIMERS-1:0]   ctl_en,
    input logic [NUM_TIMERS-1:0]   en_rise,
    input logic [NUM_TIMERS-1:0]   en_fall,
    input logic [NUM_TIMERS-1:0]   slot_wr,
    input logic [NUM_TIMERS-1:0]   slot_rd,
    input logic [NUM_TIMERS-1:0]   sts,
    input logic [4*NUM_TIMERS-1:0] cur_word,
    input logic                    lock_bit
);
    // R3
    rise_sets_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_rise & ~ctl_en) == '0);
    // R3
    rise_from_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_rise & $past(ctl_en)) == '0);
    // R3
    fall_clears_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_fall & ctl_en) == '0);
    // R3
    rise_fall_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_rise & en_fall) == '0);
    // R7
    evt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_pulse) |=> ((sts & $past(evt_pulse)) == $past(evt_pulse)));
    // R1
    slot_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slot_wr) && $onehot0(slot_rd));
    // R9
    misaligned_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr[1:0] != 2'b00)) |=> ($stable(cur_word) && $stable(lock_bit)));
    // R10
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cur_word == '0 && sts == '0 && !lock_bit));
endmodule

bind tcb_bank tcb_bank_chk #(.ADDR_W(ADDR_W), .NUM_TIMERS(NUM_TIMERS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .evt_pulse (evt_pulse),
    .ctl_en    (ctl_en),
    .en_rise   (en_rise),
    .en_fall   (en_fall),
    .slot_wr   (slot_wr),
    .slot_rd   (slot_rd),
    .sts       (sts_q),
    .cur_word  (cur_word),
    .lock_bit  (lock_bit)
);

// File: tb/tb_tcb_bank.sv
// Self-checking bench for tcb_bank: a vector table, then directed tests.
module tb_tcb_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rd_data;
    logic [31:0] tmr_rdata;
    logic [7:0]  evt_pulse = '0;
    logic [7:0]  slot_wr, slot_rd, ctl_en, ctl_ext_clk, ctl_ovf_irq, ctl_pulse;
    logic [7:0]  en_rise, en_fall;
    logic [1:0]  slot_word;
    logic        pulse_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    // Stand-in channel data: which window and which word were selected
    assign tmr_rdata = {slot_rd, 22'b0, slot_word};

    tcb_bank dut (
        .clk, .rst_n, .bus_addr, .bus_wr, .bus_rd, .bus_wdata, .rd_data,
        .tmr_rdata, .evt_pulse, .slot_wr, .slot_rd, .slot_word, .ctl_en,
        .ctl_ext_clk, .ctl_ovf_irq, .ctl_pulse, .en_rise, .en_fall, .pulse_err
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        d = rd_data;
        bus_rd = 1'b0;
    endtask

    task automatic pulse(input logic [7:0] v);
        evt_pulse = v;
        @(negedge clk);
        evt_pulse = '0;
    endtask

    typedef struct packed {
        logic        is_rd;
        logic [11:0] addr;
        logic [31:0] data;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 12'h030, 32'h0, 8'd10},          // R10 control word at reset
        '{1'b1, 12'h034, 32'h0, 8'd10},          // R10 status at reset
        '{1'b1, 12'h038, 32'h0, 8'd10},          // R10 locked at reset
        '{1'b0, 12'h030, 32'h13, 8'd0},
        '{1'b1, 12'h030, 32'h13, 8'd2},          // R2 readback
        '{1'b0, 12'h03C, 32'h01, 8'd0},
        '{1'b1, 12'h030, 32'h13, 8'd5},          // R5 locked clear ignored
        '{1'b0, 12'h038, 32'h15C, 8'd0},
        '{1'b1, 12'h038, 32'h1, 8'd6},           // R6 open key
        '{1'b0, 12'h03C, 32'h11, 8'd0},
        '{1'b1, 12'h030, 32'h02, 8'd5},          // R5 clear by ones
        '{1'b0, 12'h038, 32'h0AA, 8'd0},
        '{1'b1, 12'h038, 32'h1, 8'd6},           // R6 other key holds
        '{1'b0, 12'h038, 32'h1D4, 8'd0},
        '{1'b1, 12'h038, 32'h0, 8'd6},           // R6 close key
        '{1'b0, 12'h032, 32'hFFFF, 8'd0},
        '{1'b1, 12'h030, 32'h02, 8'd9},          // R9 misaligned write ignored
        '{1'b1, 12'h032, 32'h0, 8'd9},           // R9 misaligned read zero
        '{1'b1, 12'h03C, 32'h0, 8'd9},           // R9 clear reg reads zero
        '{1'b0, 12'h090, 32'hFFFF, 8'd0},
        '{1'b1, 12'h090, 32'h0, 8'd9},           // R9 unmapped read zero
        '{1'b1, 12'h030, 32'h02, 8'd9},          // R9 unmapped write ignored
        '{1'b1, 12'h00C, 32'h0100_0003, 8'd1},   // R1 channel 0 word 3
        '{1'b1, 12'h028, 32'h0400_0002, 8'd1},   // R1 channel 2 word 2
        '{1'b1, 12'h044, 32'h0800_0001, 8'd1},   // R1 channel 3 word 1
        '{1'b1, 12'h08C, 32'h8000_0003, 8'd1}    // R1 channel 7 word 3
    };

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10 outputs idle after reset
        chk("R10 ctl_en", 32'(ctl_en), 32'h0);
        chk("R10 rd_data", rd_data, 32'h0);

        for (int k = 0; k < NV; k++) begin
            if (VEC[k].is_rd) begin
                rd(VEC[k].addr, d);
                chk($sformatf("R%0d vec %0d", VEC[k].req, k), d, VEC[k].data);
            end else begin
                wr(VEC[k].addr, VEC[k].data);
            end
        end

        // R1 write strobe to channel 4 window word 1
        bus_addr = 12'h054; bus_wdata = 32'h1234; bus_wr = 1'b1;
        #1;
        chk("R1 slot_wr", 32'(slot_wr), 32'h10);
        chk("R1 slot_word", 32'(slot_word), 32'h1);
        @(negedge clk);
        bus_wr = 1'b0;

        // R3 start channel 2 with overflow interrupt: config first, enable next
        wr(12'h030, 32'h502);
        chk("R3 cfg first", 32'(ctl_ovf_irq), 32'h04);
        chk("R3 en not yet", 32'(ctl_en), 32'h0);
        @(negedge clk);
        chk("R3 en after", 32'(ctl_en), 32'h04);
        chk("R3 rise strobe", 32'(en_rise), 32'h04);
        @(negedge clk);
        chk("R3 rise one cycle", 32'(en_rise), 32'h0);

        // R3 stop channel 2: enable and config drop together
        wr(12'h030, 32'h002);
        chk("R3 stop en", 32'(ctl_en), 32'h0);
        chk("R3 fall strobe", 32'(en_fall), 32'h04);
        chk("R3 stop cfg", 32'(ctl_ovf_irq), 32'h0);
        @(negedge clk);
        chk("R3 fall one cycle", 32'(en_fall), 32'h0);

        // R3 start then immediate stop: nothing rises
        wr(12'h030, 32'h003);
        wr(12'h030, 32'h002);
        chk("R3 cancel en", 32'(ctl_en), 32'h0);
        chk("R3 cancel strobes", 32'({en_rise, en_fall}), 32'h0);
        @(negedge clk);
        chk("R3 cancel no rise", 32'({ctl_en, en_rise}), 32'h0);

        // R4 pulse mode on channel 1 (incapable) and channel 5 (capable)
        wr(12'h030, 32'h0080_0082);
        chk("R4 pulse_err", 32'(pulse_err), 32'h1);
        chk("R4 ctl_pulse", 32'(ctl_pulse), 32'h20);
        rd(12'h030, d);
        chk("R4 readback", d, 32'h0080_0082);
        chk("R4 err one cycle", 32'(pulse_err), 32'h0);

        // R5 clear through the unlocked path
        wr(12'h038, 32'h15C);
        wr(12'h03C, 32'h0080_0080);
        chk("R5 pulse cleared", 32'(ctl_pulse), 32'h0);
        rd(12'h030, d);
        chk("R5 word", d, 32'h02);
        wr(12'h038, 32'h1D4);

        // R7 events set bits; AND write clears
        pulse(8'h04);
        rd(12'h034, d);
        chk("R7 evt 2", d, 32'h04);
        pulse(8'h20);
        rd(12'h034, d);
        chk("R7 evt 5", d, 32'h24);
        wr(12'h034, 32'hFFFF_FFDF);
        rd(12'h034, d);
        chk("R7 and mask", d, 32'h04);

        // R8 event in the same cycle as a clearing write
        evt_pulse = 8'h01;
        wr(12'h034, 32'h0);
        evt_pulse = '0;
        rd(12'h034, d);
        chk("R8 event wins", d, 32'h01);

        // R10 reset mid-run
        wr(12'h030, 32'h0100_0000);
        wr(12'h038, 32'h15C);
        pulse(8'h80);
        chk("R10 pre en", 32'(ctl_en), 32'h40);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk("R10 en cleared", 32'(ctl_en), 32'h0);
        rd(12'h030, d);
        chk("R10 ctl cleared", d, 32'h0);
        rd(12'h034, d);
        chk("R10 sts cleared", d, 32'h0);
        rd(12'h038, d);
        chk("R10 lock cleared", d, 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule